// File: doc/BRIEF.md
# Two-Level Priority Interrupt Controller

This block collects interrupt events from on-chip peripherals and from external pins into request flags. Each flag has its own enable bit and priority bit. From these it drives two request lines to a processor: one for urgent work and one for background work. A mode bit picks how requests are made. With the bit set there are two priority levels. With the bit clear there is one level, which keeps the behaviour of older single-level software.

The controller has two kinds of core source. The first is a set of external pins, each with its own choice of rising or falling edge. The second is a change detector that watches a small group of port pins against a snapshot of them. That snapshot is refreshed whenever software reads the port. Peripheral sources arrive as one-cycle event pulses. Software reaches the block through a flat register bus: writes take effect at a clock edge, and reads return data combinationally.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, the global control register (address 0), all flag registers (addresses 1 and 4) and all enable registers (addresses 2 and 5) read 0. The core configuration register (address 3) reads 0x7F, meaning every core priority is high and every external edge select is rising. The peripheral priority register (address 6) reads 0xFF. Both request outputs are low.
- R2: External pin k sets core flag bit k when its synchronised level makes the transition chosen by edge-select bit 4+k of address 3 (1 = rising, 0 = falling). The opposite transition leaves the flag unchanged.
- R3: Any source event sets its flag, whatever the state of that source's enable bit and of the global bits, so software can poll the flags.
- R4: A register write loads flag bits from the written data, so writing 0 clears a flag. If a set event for a flag arrives in the same cycle as that write, the flag ends up set.
- R5: Core flag bit 3 (port change) is set on every cycle in which any port pin whose per-pin enable (address 2, bits 7:4) is 1 differs from its latched snapshot. Pins whose enable is 0 are ignored. A read of address 7 returns the synchronised pins and loads them into the snapshot, which ends the mismatch.
- R6: With priority mode on (address 0 bit 0 = 1), hi_req is high exactly when global bit 7 is 1 and at least one source has its flag, its enable and its priority bit (1 = high) all set.
- R7: With priority mode on, lo_req is high exactly when global bits 7 and 6 are both 1 and at least one source has its flag and enable set and priority bit 0.
- R8: With priority mode off, lo_req stays 0 and all sources count as high priority. Then hi_req = bit7 AND (any enabled core flag OR (bit6 AND any enabled peripheral flag)).
- R9: A flag whose enable bit is 0 never causes either request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_pin | input | N_EXT | Asynchronous external interrupt pins |
| port_pin | input | PORT_W | Asynchronous port pins watched for change |
| per_evt | input | 8 | One-cycle peripheral event pulses, bit i sets peripheral flag i |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe; a read of address 7 refreshes the port snapshot |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Read data, combinational from rd_addr |
| hi_req | output | 1 | High-priority request to the processor |
| lo_req | output | 1 | Low-priority request to the processor |

## Verification
The case that needs care is a software write of zero to a flag register landing in the same cycle as the event that sets that flag. The bench provokes this by driving a peripheral pulse on the same clock edge as a clearing write to the peripheral flag register, and it requires the flag to read back as 1. A second case of the same kind uses the port-change flag: a clearing write issued while a port mismatch still holds must leave the flag set. Only after the port has been read does the same write clear it.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_GLOBAL = 3'd0,
    RA_CFLAG  = 3'd1,
    RA_CEN    = 3'd2,
    RA_CCFG   = 3'd3,
    RA_PFLAG  = 3'd4,
    RA_PEN    = 3'd5,
    RA_PPRIO  = 3'd6,
    RA_PORT   = 3'd7
  } reg_addr_e;

  localparam int GB_HI   = 7;
  localparam int GB_LO   = 6;
  localparam int GB_MODE = 0;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic rise_sel,
  output logic level,
  output logic evt
);
  logic [STAGES-1:0] sh_q, sh_d;
  logic              prev_q;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], pin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign level = sh_q[STAGES-1];
  assign evt   = rise_sel ? (level & ~prev_q) : (~level & prev_q);
endmodule

// File: rtl/irq_port_watch.sv
module irq_port_watch #(
  parameter int PORT_W = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORT_W-1:0] pins,
  input  logic [PORT_W-1:0] pin_en,
  input  logic              snap,
  output logic [PORT_W-1:0] level,
  output logic              mismatch
);
  logic [PORT_W-1:0] snap_q, snap_d;
  logic [PORT_W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= pins;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign level = stage_q[STAGES-1];

  always_comb begin
    snap_d = snap_q;
    if (snap) snap_d = level;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign mismatch = |((level ^ snap_q) & pin_en);
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import prio_irq_pkg::*;
#(
  parameter int CORE_N = 4,
  parameter int PORT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [CORE_N-1:0] core_set,
  input  logic [DATA_W-1:0] per_set,
  input  logic [PORT_W-1:0] port_level,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] glob_q,
  output logic [DATA_W-1:0] cflag_q,
  output logic [DATA_W-1:0] cen_q,
  output logic [DATA_W-1:0] ccfg_q,
  output logic [DATA_W-1:0] pflag_q,
  output logic [DATA_W-1:0] pen_q,
  output logic [DATA_W-1:0] pprio_q
);
  localparam int N_EXT = CORE_N - 1;
  localparam logic [DATA_W-1:0] CCFG_RST =
    DATA_W'((1 << (CORE_N + N_EXT)) - 1);
  localparam logic [DATA_W-1:0] CFLAG_MASK = DATA_W'((1 << CORE_N) - 1);

  logic [DATA_W-1:0] glob_d, cflag_d, cen_d, ccfg_d, pflag_d, pen_d, pprio_d;
  logic [DATA_W-1:0] core_set_w;

  assign core_set_w = DATA_W'(core_set);

  always_comb begin
    glob_d  = glob_q;
    cflag_d = cflag_q;
    cen_d   = cen_q;
    ccfg_d  = ccfg_q;
    pflag_d = pflag_q;
    pen_d   = pen_q;
    pprio_d = pprio_q;
    if (wr_en) begin
      unique case (reg_addr_e'(wr_addr))
        RA_GLOBAL: glob_d  = wr_data;
        RA_CFLAG:  cflag_d = wr_data & CFLAG_MASK;
        RA_CEN:    cen_d   = wr_data;
        RA_CCFG:   ccfg_d  = wr_data & CCFG_RST;
        RA_PFLAG:  pflag_d = wr_data;
        RA_PEN:    pen_d   = wr_data;
        RA_PPRIO:  pprio_d = wr_data;
        default:   ;
      endcase
    end
    cflag_d = cflag_d | core_set_w;
    pflag_d = pflag_d | per_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_q  <= '0;
      cflag_q <= '0;
      cen_q   <= '0;
      ccfg_q  <= CCFG_RST;
      pflag_q <= '0;
      pen_q   <= '0;
      pprio_q <= '1;
    end else begin
      glob_q  <= glob_d;
      cflag_q <= cflag_d;
      cen_q   <= cen_d;
      ccfg_q  <= ccfg_d;
      pflag_q <= pflag_d;
      pen_q   <= pen_d;
      pprio_q <= pprio_d;
    end
  end

  always_comb begin
    unique case (reg_addr_e'(rd_addr))
      RA_GLOBAL: rd_data = glob_q;
      RA_CFLAG:  rd_data = cflag_q;
      RA_CEN:    rd_data = cen_q;
      RA_CCFG:   rd_data = ccfg_q;
      RA_PFLAG:  rd_data = pflag_q;
      RA_PEN:    rd_data = pen_q;
      RA_PPRIO:  rd_data = pprio_q;
      RA_PORT:   rd_data = DATA_W'(port_level);
      default:   rd_data = '0;
    endcase
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen
  import prio_irq_pkg::*;
#(
  parameter int CORE_N = 4
) (
  input  logic [DATA_W-1:0] glob,
  input  logic [CORE_N-1:0] cflag,
  input  logic [CORE_N-1:0] cen,
  input  logic [CORE_N-1:0] cprio,
  input  logic [DATA_W-1:0] pflag,
  input  logic [DATA_W-1:0] pen,
  input  logic [DATA_W-1:0] pprio,
  output logic              hi_req,
  output logic              lo_req
);
  logic [CORE_N-1:0] core_act;
  logic [DATA_W-1:0] per_act;
  logic              any_hi, any_lo, g_hi, g_lo;

  always_comb begin
    core_act = cflag & cen;
    per_act  = pflag & pen;
    g_hi     = glob[GB_HI];
    g_lo     = glob[GB_LO];
    any_hi   = |(core_act & cprio) | |(per_act & pprio);
    any_lo   = |(core_act & ~cprio) | |(per_act & ~pprio);
    if (glob[GB_MODE]) begin
      hi_req = g_hi & any_hi;
      lo_req = g_hi & g_lo & any_lo;
    end else begin
      hi_req = g_hi & ((|core_act) | (g_lo & (|per_act)));
      lo_req = 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int N_EXT       = 3,
  parameter int PORT_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_EXT-1:0]  ext_pin,
  input  logic [PORT_W-1:0] port_pin,
  input  logic [DATA_W-1:0] per_evt,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              hi_req,
  output logic              lo_req
);
  localparam int CORE_N   = N_EXT + 1;
  localparam int PIN_EN_L = CORE_N;
  localparam int EDGE_L   = CORE_N;

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic [DATA_W-1:0] glob_q, cflag_q, cen_q, ccfg_q, pflag_q, pen_q, pprio_q;
  logic [N_EXT-1:0]  ext_evt, ext_lvl;
  logic [PORT_W-1:0] port_lvl;
  logic              port_mis, port_snap;
  logic [CORE_N-1:0] core_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  for (genvar k = 0; k < N_EXT; k++) begin : g_ext
    irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_core_n),
      .pin      (ext_pin[k]),
      .rise_sel (ccfg_q[EDGE_L + k]),
      .level    (ext_lvl[k]),
      .evt      (ext_evt[k])
    );
  end

  assign port_snap = rd_en && (reg_addr_e'(rd_addr) == RA_PORT);

  irq_port_watch #(.PORT_W(PORT_W), .STAGES(SYNC_STAGES)) u_port (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .pins     (port_pin),
    .pin_en   (cen_q[PIN_EN_L +: PORT_W]),
    .snap     (port_snap),
    .level    (port_lvl),
    .mismatch (port_mis)
  );

  assign core_set = {port_mis, ext_evt};

  irq_regfile #(.CORE_N(CORE_N), .PORT_W(PORT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .rd_addr    (rd_addr),
    .core_set   (core_set),
    .per_set    (per_evt),
    .port_level (port_lvl),
    .rd_data    (rd_data),
    .glob_q     (glob_q),
    .cflag_q    (cflag_q),
    .cen_q      (cen_q),
    .ccfg_q     (ccfg_q),
    .pflag_q    (pflag_q),
    .pen_q      (pen_q),
    .pprio_q    (pprio_q)
  );

  irq_req_gen #(.CORE_N(CORE_N)) u_req (
    .glob   (glob_q),
    .cflag  (cflag_q[CORE_N-1:0]),
    .cen    (cen_q[CORE_N-1:0]),
    .cprio  (ccfg_q[CORE_N-1:0]),
    .pflag  (pflag_q),
    .pen    (pen_q),
    .pprio  (pprio_q),
    .hi_req (hi_req),
    .lo_req (lo_req)
  );
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] glob,
  input logic [DATA_W-1:0] pflag,
  input logic [DATA_W-1:0] per_evt,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              hi_req,
  input logic              lo_req
);
  AST_COMPAT_NO_LO: assert property (@(posedge clk) disable iff (!rst_n)
    !glob[GB_MODE] |-> !lo_req); // R8

  AST_LO_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    lo_req |-> (glob[GB_HI] && glob[GB_LO])); // R7

  AST_HI_NEEDS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    hi_req |-> glob[GB_HI]); // R6

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (|per_evt) |=> ((pflag & $past(per_evt)) == $past(per_evt))); // R3

  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == RA_PFLAG && wr_data == '0 && per_evt == '0)
      |=> (pflag == '0)); // R4
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .glob    (glob_q),
  .pflag   (pflag_q),
  .per_evt (per_evt),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .hi_req  (hi_req),
  .lo_req  (lo_req)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ext_pin;
  logic [3:0] port_pin;
  logic [7:0] per_evt;
  logic       wr_en;
  logic [2:0] wr_addr;
  logic [7:0] wr_data;
  logic       rd_en;
  logic [2:0] rd_addr;
  logic [7:0] rd_data;
  logic       hi_req, lo_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  prio_irq_ctrl u_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_pin(port_pin),
    .per_evt(per_evt), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .hi_req(hi_req), .lo_req(lo_req)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    #0.5 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] m);
    @(negedge clk);
    per_evt = m;
    @(negedge clk);
    per_evt = '0;
  endtask

  task automatic reqs(input string req, input logic eh, input logic el);
    #0.5;
    check({req, " hi_req"}, int'(hi_req), int'(eh));
    check({req, " lo_req"}, int'(lo_req), int'(el));
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(3'd0, d); check("R1 global", d, 8'h00);
    rd(3'd1, d); check("R1 core flag", d, 8'h00);
    rd(3'd2, d); check("R1 core en", d, 8'h00);
    rd(3'd3, d); check("R1 core cfg", d, 8'h7F);
    rd(3'd4, d); check("R1 per flag", d, 8'h00);
    rd(3'd5, d); check("R1 per en", d, 8'h00);
    rd(3'd6, d); check("R1 per prio", d, 8'hFF);
    reqs("R1", 1'b0, 1'b0);
  endtask

  task automatic t_ext_edges();
    logic [7:0] d;
    wr(3'd0, 8'hC1);
    @(negedge clk); ext_pin[0] = 1'b1;
    idle(5);
    rd(3'd1, d); check("R2 rising sets flag0 (R3 polled)", d, 8'h01);
    reqs("R9 disabled flag", 1'b0, 1'b0);
    wr(3'd1, 8'h00);
    rd(3'd1, d); check("R4 write zero clears", d, 8'h00);
    wr(3'd3, 8'h6F);
    @(negedge clk); ext_pin[0] = 1'b0; ext_pin[1] = 1'b1;
    idle(5);
    rd(3'd1, d); check("R2 falling sel0 and rising sel1", d, 8'h03);
    wr(3'd1, 8'h00);
    @(negedge clk); ext_pin[0] = 1'b1; ext_pin[1] = 1'b0;
    idle(5);
    rd(3'd1, d); check("R2 opposite edges ignored", d, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_port();
    logic [7:0] d;
    wr(3'd2, 8'h10);
    @(negedge clk); port_pin[1] = 1'b1;
    idle(5);
    rd(3'd1, d); check("R5 disabled pin ignored", d, 8'h00);
    @(negedge clk); port_pin[0] = 1'b1;
    idle(5);
    rd(3'd1, d); check("R5 mismatch sets flag3", d, 8'h08);
    wr(3'd1, 8'h00);
    rd(3'd1, d); check("R5 mismatch re-sets after clear", d, 8'h08);
    rd(3'd7, d); check("R5 port read value", d, 8'h03);
    wr(3'd1, 8'h00);
    idle(2);
    rd(3'd1, d); check("R5 clear after port read", d, 8'h00);
    wr(3'd2, 8'h00);
  endtask

  task automatic t_priority();
    logic [7:0] d;
    wr(3'd6, 8'hFE);
    wr(3'd5, 8'h03);
    pulse_evt(8'h03);
    rd(3'd4, d); check("R3 per flags", d, 8'h03);
    reqs("R6 globals off", 1'b0, 1'b0);
    wr(3'd0, 8'h81); reqs("R6 high only", 1'b1, 1'b0);
    wr(3'd0, 8'hC1); reqs("R7 both levels", 1'b1, 1'b1);
    wr(3'd0, 8'h41); reqs("R7 bit7 off", 1'b0, 1'b0);
    wr(3'd0, 8'hC1);
    wr(3'd4, 8'h01); reqs("R7 low only", 1'b0, 1'b1);
    wr(3'd5, 8'h00); reqs("R9 enables off", 1'b0, 1'b0);
    wr(3'd5, 8'h01);
    wr(3'd0, 8'h80); reqs("R8 periph gated", 1'b0, 1'b0);
    wr(3'd0, 8'hC0); reqs("R8 periph via bit6", 1'b1, 1'b0);
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h80);
    wr(3'd1, 8'h02);
    wr(3'd2, 8'h02); reqs("R8 core without bit6", 1'b1, 1'b0);
    wr(3'd1, 8'h00); reqs("R8 core cleared", 1'b0, 1'b0);
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h00);
  endtask

  task automatic t_collision();
    logic [7:0] d;
    wr(3'd4, 8'h10);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'd4; wr_data = 8'h00; per_evt = 8'h04;
    @(negedge clk);
    wr_en = 1'b0; per_evt = '0;
    rd(3'd4, d); check("R4 set wins over clear", d, 8'h04);
    wr(3'd4, 8'h00);
    rd(3'd4, d); check("R4 plain clear", d, 8'h00);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_pin = '0; port_pin = '0; per_evt = '0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_en = 1'b0; rd_addr = '0;
    idle(5);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_ext_edges();
    t_port();
    t_priority();
    t_collision();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule